// File: doc/BRIEF.md
# G.711 Receive-Path Sample Expander

This block sits between a serial audio receiver and the linear datapath that feeds a DAC. It watches a bit clock, a frame clock and a serial data line and cuts the stream into words. Each word is turned into a signed 16-bit linear sample, which is presented with a one-cycle strobe in the system clock domain. The three serial lines are asynchronous to the system clock. They are brought in through synchronizers, and each bit is taken on a rising edge of the bit clock seen in the system clock domain.

Two control inputs pick one of four modes: a companding enable and a type select. With companding on, the type select chooses μ-law or A-law expansion. With companding off, the type select chooses between plain 8-bit linear samples and full 16-bit pass-through. Every mode other than pass-through uses 8-bit words. Words can follow each other with no gap, so a single frame pulse can be followed by any number of words at the mode's word length. The mode is taken from the control inputs only when a frame starts. A control change in the middle of a frame therefore affects only the next frame.

Top module: `g711x_rx_expander`

## Requirements
- R1: The mode is {comp_en, comp_type}: 2'b10 is μ-law, 2'b11 is A-law, 2'b01 is 8-bit linear and 2'b00 is 16-bit pass-through.
- R2: A frame starts on a rising edge of the bit clock at which the frame clock is high and was low at the previous rising edge. That same edge carries the word's MSB, and bits follow MSB first, one per rising edge. A new frame start abandons any partial word.
- R3: The word length is 8 bits in μ-law, A-law and 8-bit linear mode, and 16 bits in pass-through mode.
- R4: After a frame start, consecutive groups of word-length bits each form a word. No further frame pulse is needed, so 8-bit words may arrive every 8 bit clocks.
- R5: The mode is latched only at a frame start. A change of comp_en or comp_type after a frame has started does not alter how the words of that frame are decoded.
- R6: μ-law: all 8 code bits are inverted, giving sign s = bit 7, segment e = bits 6:4 and mantissa m = bits 3:0. Magnitude = (((m·8)+132)·2^e) − 132, and a set s means negative. Code 0xFF gives 0 and code 0x00 gives −32124.
- R7: A-law: the code is XORed with 0x55, with the same field positions. Magnitude = m·16+8 for e = 0, otherwise (m·16+264)·2^(e−1), and a set s means positive. Code 0xD5 gives +8 and code 0x2A gives −32256.
- R8: 8-bit linear: the word is a two's-complement value placed in output bits 15:8, with bits 7:0 zero.
- R9: Pass-through: the 16-bit word appears unchanged on the output.
- R10: Each completed word gives exactly one pcm_valid pulse one system clock wide. pcm_data holds its value until the next pulse.
- R11: After reset pcm_valid is 0 and pcm_data is 0. Bits that arrive before the first frame start produce no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, asynchronous |
| lrclk | input | 1 | Serial frame clock, asynchronous |
| sdata | input | 1 | Serial data, MSB first |
| comp_en | input | 1 | Companding enable |
| comp_type | input | 1 | Type select (A-law / 8-bit linear when 1) |
| pcm_data | output | 16 | Signed linear sample |
| pcm_valid | output | 1 | One-cycle strobe per completed word |

## Verification
Every one of the 256 μ-law and 256 A-law codes is streamed back to back after a single frame pulse. A wrong inversion mask, a swapped sign sense or an off-by-one segment shift would show as wrong samples, and a miscounted word length would show as shifted or missing words. The control inputs are flipped part-way through a frame: a design that follows them live would decode the later words with the wrong law. A frame pulse is sent in the middle of a word, where a design that does not restart would produce a spurious mixed word. Stray bits are sent before any frame, where a design that captures them would emit samples after reset.

// File: rtl/g711x_pkg.sv
package g711x_pkg;
  typedef enum logic [1:0] {
    MODE_PASS16 = 2'b00,
    MODE_LIN8   = 2'b01,
    MODE_ULAW   = 2'b10,
    MODE_ALAW   = 2'b11
  } xmode_e;

  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned CODE_W   = 8;
  localparam logic [CODE_W-1:0] ULAW_FLIP = 8'hFF;
  localparam logic [CODE_W-1:0] ALAW_FLIP = 8'h55;
  localparam logic [SAMPLE_W-1:0] ULAW_BIAS = 16'h0084;
  localparam logic [SAMPLE_W-1:0] ALAW_SEG_BIAS = 16'h0108;
  localparam logic [SAMPLE_W-1:0] ALAW_LOW_BIAS = 16'h0008;
endpackage

// File: rtl/g711x_sync.sv
module g711x_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/g711x_word_capture.sv
module g711x_word_capture
  import g711x_pkg::*;
#(
  parameter int unsigned WORD_W  = SAMPLE_W,
  parameter int unsigned SHORT_W = CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              lr_bit,
  input  logic              sd_bit,
  input  xmode_e            mode_in,
  output xmode_e            mode_q,
  output logic              frame_start,
  output logic              word_stb,
  output logic [WORD_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_W - 1);

  logic [WORD_W-1:0] sh_q, sh_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              lr_prev_q, lr_prev_n;
  logic              active_q, active_n;
  logic              done_q, done_n;
  xmode_e            mode_n;
  logic [CNT_W-1:0]  last_idx;

  assign frame_start = bit_stb && lr_bit && !lr_prev_q;
  assign last_idx    = (mode_q == MODE_PASS16) ? LAST_LONG : LAST_SHORT;

  always_comb begin
    sh_n      = sh_q;
    cnt_n     = cnt_q;
    lr_prev_n = lr_prev_q;
    active_n  = active_q;
    mode_n    = mode_q;
    done_n    = 1'b0;
    if (bit_stb) begin
      lr_prev_n = lr_bit;
      if (frame_start) begin
        mode_n   = mode_in;
        sh_n     = {{(WORD_W-1){1'b0}}, sd_bit};
        cnt_n    = CNT_W'(1);
        active_n = 1'b1;
      end else if (active_q) begin
        sh_n = {sh_q[WORD_W-2:0], sd_bit};
        if (cnt_q == last_idx) begin
          done_n = 1'b1;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      lr_prev_q <= 1'b0;
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      mode_q    <= MODE_PASS16;
    end else begin
      sh_q      <= sh_n;
      cnt_q     <= cnt_n;
      lr_prev_q <= lr_prev_n;
      active_q  <= active_n;
      done_q    <= done_n;
      mode_q    <= mode_n;
    end
  end

  assign word_stb = done_q;
  assign word     = sh_q;
endmodule

// File: rtl/g711x_expand.sv
module g711x_expand
  import g711x_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_stb,
  input  logic [SAMPLE_W-1:0] word,
  input  xmode_e              mode,
  output logic [SAMPLE_W-1:0] pcm,
  output logic                pcm_vld
);
  logic [CODE_W-1:0]   code, flip;
  logic                sgn;
  logic [2:0]          seg;
  logic [3:0]          man;
  logic [SAMPLE_W-1:0] u_mag, a_mag, a_base, dec_n, pcm_q;
  logic [2:0]          a_shift;
  logic                vld_q;

  assign code = word[CODE_W-1:0];
  assign flip = code ^ ((mode == MODE_ALAW) ? ALAW_FLIP : ULAW_FLIP);
  assign sgn  = flip[7];
  assign seg  = flip[6:4];
  assign man  = flip[3:0];

  always_comb begin
    u_mag   = (({9'b0, man, 3'b000} + ULAW_BIAS) << seg) - ULAW_BIAS;
    a_base  = {8'b0, man, 4'b0000} + ((seg == 3'd0) ? ALAW_LOW_BIAS : ALAW_SEG_BIAS);
    a_shift = (seg == 3'd0) ? 3'd0 : (seg - 3'd1);
    a_mag   = a_base << a_shift;
    unique case (mode)
      MODE_ULAW: dec_n = sgn ? (16'h0000 - u_mag) : u_mag;
      MODE_ALAW: dec_n = sgn ? a_mag : (16'h0000 - a_mag);
      MODE_LIN8: dec_n = {code, 8'h00};
      default:   dec_n = word;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= word_stb;
      if (word_stb) pcm_q <= dec_n;
    end
  end

  assign pcm     = pcm_q;
  assign pcm_vld = vld_q;
endmodule

// File: rtl/g711x_rx_expander.sv
module g711x_rx_expander
  import g711x_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        sdata,
  input  logic        comp_en,
  input  logic        comp_type,
  output logic [15:0] pcm_data,
  output logic        pcm_valid
);
  localparam int unsigned LINES = 3;

  logic [1:0]        rst_pipe_q;
  logic              rst_n_sync;
  logic [LINES-1:0]  lines_s;
  logic              bclk_d_q;
  logic              bit_stb;
  xmode_e            mode_in, mode_q;
  logic              frame_start, word_stb;
  logic [SAMPLE_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe_q[1];

  g711x_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .async_in ({bclk, lrclk, sdata}),
    .sync_out (lines_s)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) bclk_d_q <= 1'b0;
    else             bclk_d_q <= lines_s[2];
  end
  assign bit_stb = lines_s[2] && !bclk_d_q;
  assign mode_in = xmode_e'({comp_en, comp_type});

  g711x_word_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .bit_stb     (bit_stb),
    .lr_bit      (lines_s[1]),
    .sd_bit      (lines_s[0]),
    .mode_in     (mode_in),
    .mode_q      (mode_q),
    .frame_start (frame_start),
    .word_stb    (word_stb),
    .word        (word)
  );

  g711x_expand u_exp (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .word_stb (word_stb),
    .word     (word),
    .mode     (mode_q),
    .pcm      (pcm_data),
    .pcm_vld  (pcm_valid)
  );
endmodule

// File: rtl/g711x_rx_checker.sv
module g711x_rx_checker
  import g711x_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        pcm_valid,
  input logic [15:0] pcm_data,
  input xmode_e      mode_q,
  input logic        frame_start
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid); // R10

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_valid |-> $stable(pcm_data)); // R10

  AST_MODE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_q)); // R5

  AST_ULAW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && mode_q == MODE_ULAW) |->
      (pcm_data[1:0] == 2'b00 && ($signed(pcm_data) <= 16'sd32124) &&
       ($signed(pcm_data) >= -16'sd32124))); // R6

  AST_ALAW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && mode_q == MODE_ALAW) |->
      (pcm_data[2:0] == 3'b000 && pcm_data != 16'h0000)); // R7

  AST_LIN8_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && mode_q == MODE_LIN8) |-> pcm_data[7:0] == 8'h00); // R8
endmodule

bind g711x_rx_expander g711x_rx_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .pcm_valid   (pcm_valid),
  .pcm_data    (pcm_data),
  .mode_q      (mode_q),
  .frame_start (frame_start)
);

// File: tb/g711x_rx_expander_test.sv
module g711x_rx_expander_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic comp_en = 1'b0, comp_type = 1'b0;
  logic [15:0] pcm_data;
  logic pcm_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [15:0] got[$];
  int max_run = 0;
  int run = 0;

  always #2.5 clk = ~clk;

  g711x_rx_expander uut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .comp_en(comp_en), .comp_type(comp_type),
    .pcm_data(pcm_data), .pcm_valid(pcm_valid)
  );

  always @(negedge clk) begin
    if (pcm_valid) begin
      got.push_back(pcm_data);
      run = run + 1;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  function automatic logic [15:0] ref_ulaw(input logic [7:0] c);
    int x, s, e, m, mag;
    x = (~c) & 8'hFF;
    s = (x >> 7) & 1; e = (x >> 4) & 7; m = x & 15;
    mag = (((m * 8) + 132) * (1 << e)) - 132;
    return 16'(s ? -mag : mag);
  endfunction

  function automatic logic [15:0] ref_alaw(input logic [7:0] c);
    int x, s, e, m, mag;
    x = c ^ 8'h55;
    s = (x >> 7) & 1; e = (x >> 4) & 7; m = x & 15;
    if (e == 0) mag = m * 16 + 8;
    else        mag = (m * 16 + 264) * (1 << (e - 1));
    return 16'(s ? mag : -mag);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic lr, input logic b);
    @(negedge clk);
    bclk = 1'b0; lrclk = lr; sdata = b;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w, input int wl, input bit first);
    for (int i = wl - 1; i >= 0; i--) send_bit(first && (i == wl - 1), w[i]);
  endtask

  task automatic settle();
    lrclk = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R11 reset data", pcm_data, 16'h0000);
    check("R11 reset valid", {15'b0, pcm_valid}, 16'h0000);
    got.delete();
    comp_en = 1'b1; comp_type = 1'b0;
    for (int i = 0; i < 12; i++) send_bit(1'b0, i[0]);
    settle();
    check_int("R11 no word before frame", got.size(), 0);
    check("R11 data still zero", pcm_data, 16'h0000);
  endtask

  task automatic t_ulaw_sweep();
    got.delete();
    comp_en = 1'b1; comp_type = 1'b0;
    for (int c = 0; c < 256; c++) send_word(16'(c), 8, c == 0);
    settle();
    check_int("R4 ulaw word count", got.size(), 256);
    if (got.size() == 256) begin
      for (int c = 0; c < 256; c++) check("R6 ulaw code", got[c], ref_ulaw(8'(c)));
      check("R6 ulaw 0xFF is zero", got[255], 16'h0000);
      check("R6 ulaw 0x00 is -32124", got[0], 16'(-32124));
    end
  endtask

  task automatic t_alaw_sweep();
    got.delete();
    comp_en = 1'b1; comp_type = 1'b1;
    for (int c = 0; c < 256; c++) send_word(16'(c), 8, c == 0);
    settle();
    check_int("R7 alaw word count", got.size(), 256);
    if (got.size() == 256) begin
      for (int c = 0; c < 256; c++) check("R7 alaw code", got[c], ref_alaw(8'(c)));
      check("R7 alaw 0xD5 is +8", got[8'hD5], 16'h0008);
      check("R7 alaw 0x2A is -32256", got[8'h2A], 16'(-32256));
    end
  endtask

  task automatic t_lin8();
    got.delete();
    comp_en = 1'b0; comp_type = 1'b1;
    send_word(16'h0080, 8, 1'b1);
    send_word(16'h007F, 8, 1'b0);
    send_word(16'h0001, 8, 1'b0);
    settle();
    check_int("R8 R3 lin8 word count", got.size(), 3);
    if (got.size() == 3) begin
      check("R8 lin8 0x80", got[0], 16'h8000);
      check("R8 lin8 0x7F", got[1], 16'h7F00);
      check("R8 lin8 0x01", got[2], 16'h0100);
    end
  endtask

  task automatic t_pass16();
    got.delete();
    comp_en = 1'b0; comp_type = 1'b0;
    send_word(16'h8000, 16, 1'b1);
    send_word(16'h1234, 16, 1'b0);
    send_word(16'hFFFF, 16, 1'b0);
    settle();
    check_int("R9 R3 pass16 word count", got.size(), 3);
    if (got.size() == 3) begin
      check("R9 pass16 w0", got[0], 16'h8000);
      check("R9 pass16 w1", got[1], 16'h1234);
      check("R9 pass16 w2", got[2], 16'hFFFF);
    end
  endtask

  task automatic t_mode_hold();
    got.delete();
    comp_en = 1'b1; comp_type = 1'b0;
    send_bit(1'b1, 1'b0);
    comp_type = 1'b1;
    for (int i = 6; i >= 0; i--) send_bit(1'b0, 1'b0);
    send_word(16'h00D5, 8, 1'b0);
    settle();
    check_int("R5 mode hold count", got.size(), 2);
    if (got.size() == 2) begin
      check("R5 first word stays ulaw", got[0], ref_ulaw(8'h00));
      check("R5 second word stays ulaw", got[1], ref_ulaw(8'hD5));
    end
    got.delete();
    send_word(16'h00D5, 8, 1'b1);
    settle();
    check_int("R1 new frame count", got.size(), 1);
    if (got.size() == 1) check("R1 new frame uses alaw", got[0], 16'h0008);
  endtask

  task automatic t_restart();
    got.delete();
    comp_en = 1'b0; comp_type = 1'b1;
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b1);
    send_bit(1'b0, 1'b1);
    send_word(16'h0042, 8, 1'b1);
    settle();
    check_int("R2 restart count", got.size(), 1);
    if (got.size() == 1) check("R2 restart word", got[0], 16'h4200);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_ulaw_sweep();
    t_alaw_sweep();
    t_lin8();
    t_pass16();
    t_mode_hold();
    t_restart();
    check_int("R10 valid pulse width", max_run, 1);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule